// File: doc/BRIEF.md
# SIMD Immediate Logic and Shuffle Unit

This unit executes one 128-bit vector operation per accepted instruction. Every operation takes an 8-bit immediate as its control operand. There are three groups of operations. The first applies a bytewise logic function (AND, OR, NOR, XOR) between every byte of the source vector and the immediate. The second merges the source vector into the old destination vector, and the immediate or the old destination decides which bits come from where. The third permutes lanes of the source vector at byte, halfword or word granularity, using 2-bit selector fields taken from the immediate.

An issuing stage presents the source vector, the current destination vector, the immediate and an operation code, and raises `in_valid`. The unit is always ready, so every cycle with `in_valid` high is an accepted instruction. The result is registered at the next clock edge, and `done` pulses for that one cycle. An operation code with no defined meaning does not change the result. Instead the unit pulses `illegal` for one cycle.

Top module: `simd_imm_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the result register, `done` and `illegal` all become 0.
- R2: Operation codes 0 (AND), 1 (OR) and 3 (XOR) produce, in every byte lane, that source byte combined with the immediate by the named function.
- R3: Operation code 2 (NOR) produces, in every byte lane, the complement of (source byte OR immediate).
- R4: Operation code 4 (merge-where-set) takes each result bit from the source where the corresponding immediate bit is 1, and from the old destination where it is 0.
- R5: Operation code 5 (merge-where-clear) takes each result bit from the source where the corresponding immediate bit is 0, and from the old destination where it is 1.
- R6: Operation code 6 (select) produces, in each byte, (source AND NOT old-destination) OR (old-destination AND immediate).
- R7: Operation code 7 (byte shuffle) fills byte lane i from source byte lane 4·floor(i/4)+k. Here k is immediate bits [2·(i mod 4)+1 : 2·(i mod 4)]. Lane 0 is bits [7:0].
- R8: Operation code 8 (halfword shuffle) applies the rule of R7 to the eight 16-bit lanes.
- R9: Operation code 9 (word shuffle) fills 32-bit word lane i from source word lane immediate[2i+1:2i].
- R10: `in_ready` is always 1. When an instruction with a defined code (0 to 9) is accepted at a clock edge, the result is updated at that same edge and `done` is high for exactly the following cycle.
- R11: When an instruction with an undefined code (10 to 15) is accepted, `illegal` is high for the following cycle, `done` stays low, and the result keeps its previous value.
- R12: In a cycle with no accepted instruction, the next edge leaves the result unchanged and both `done` and `illegal` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept (always 1) |
| op_sel | input | 4 | Operation code |
| imm | input | 8 | Immediate control byte |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Old destination vector |
| res_vec | output | 128 | Registered result |
| done | output | 1 | One-cycle pulse: result updated |
| illegal | output | 1 | One-cycle pulse: undefined operation code |

## Verification
Every accepted instruction is captured at the clock edge on which it is presented. Its `done` or `illegal` pulse and its new `res_vec` can therefore be seen from that edge until the next one. The driver changes inputs just after a rising edge. The monitor samples on the falling edge, so each pulse is compared with the oldest queued expectation exactly one half-cycle after the edge that produced it. On every falling edge without a pulse, the monitor checks that `res_vec` still equals the last expected result. Any queued item left over at the end counts as a missing pulse.

// File: rtl/simd_imm_pkg.sv
// Shared definitions for the SIMD immediate unit.
// Assumes a 4-bit operation code; codes above OP_SHF_W are undefined.
package simd_imm_pkg;

    typedef enum logic [3:0] {
        OP_AND    = 4'd0,
        OP_OR     = 4'd1,
        OP_NOR    = 4'd2,
        OP_XOR    = 4'd3,
        OP_MOVNZ  = 4'd4,
        OP_MOVZ   = 4'd5,
        OP_SEL    = 4'd6,
        OP_SHF_B  = 4'd7,
        OP_SHF_H  = 4'd8,
        OP_SHF_W  = 4'd9
    } op_e;

    localparam logic [3:0] OP_LAST    = 4'd9;
    localparam int         BYTE_W     = 8;
    localparam int         NUM_SHF    = 3;   // byte, halfword, word shuffles
    localparam int         GROUP_LANES = 4;

endpackage

// File: rtl/simd_bytelogic.sv
// Bytewise logic and bit-merge datapath.
// Applies the same immediate byte to every lane; for the merge codes the
// old destination is the third operand. Output is don't-care for shuffle codes.
module simd_bytelogic
    import simd_imm_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [3:0]       op,
    input  logic [7:0]       imm,
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] dst,
    output logic [VEC_W-1:0] out
);
    localparam int NBYTES = VEC_W / BYTE_W;

    function automatic logic [7:0] lane_fn(input logic [3:0] o, input logic [7:0] s,
                                           input logic [7:0] d, input logic [7:0] m);
        case (o)
            OP_AND:   return s & m;
            OP_OR:    return s | m;
            OP_NOR:   return ~(s | m);
            OP_XOR:   return s ^ m;
            OP_MOVNZ: return (s & m) | (d & ~m);
            OP_MOVZ:  return (s & ~m) | (d & m);
            OP_SEL:   return (s & ~d) | (d & m);
            default:  return s;
        endcase
    endfunction

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Per-lane combine of source, old destination and immediate.
        always_comb begin
            out[b*BYTE_W +: BYTE_W] = lane_fn(op, src[b*BYTE_W +: BYTE_W],
                                              dst[b*BYTE_W +: BYTE_W], imm);
        end
    end

endmodule

// File: rtl/simd_lane_shuffle.sv
// Lane permutation within aligned groups of four lanes.
// Lane i takes source lane 4*(i/4) + imm[2*(i%4)+:2]. With exactly four
// lanes this is the plain word shuffle. Assumes VEC_W/LANE_W is a multiple of 4.
module simd_lane_shuffle
    import simd_imm_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [7:0]       imm,
    input  logic [VEC_W-1:0] src,
    output logic [VEC_W-1:0] out
);
    localparam int NLANES = VEC_W / LANE_W;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        localparam int BASE = (i / GROUP_LANES) * GROUP_LANES;
        localparam int FLD  = 2 * (i % GROUP_LANES);
        logic [1:0] pick;
        // Pick the in-group source lane named by this lane's selector field.
        always_comb begin
            pick = imm[FLD +: 2];
            out[i*LANE_W +: LANE_W] = src[(BASE + int'(pick)) * LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/simd_imm_unit.sv
// SIMD immediate logic / shuffle execution unit.
// Always ready; an accepted instruction is executed combinationally and
// registered on the accepting edge, with a one-cycle done or illegal pulse.
// Assumes a synchronous active-low reset.
module simd_imm_unit
    import simd_imm_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [3:0]       op_sel,
    input  logic [7:0]       imm,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] dst_vec,
    output logic [VEC_W-1:0] res_vec,
    output logic             done,
    output logic             illegal
);
    logic             accept;
    logic             legal;
    logic [VEC_W-1:0] logic_out;
    logic [VEC_W-1:0] shf_out [NUM_SHF];
    logic [VEC_W-1:0] next_res;

    assign in_ready = 1'b1;
    assign accept   = in_valid && in_ready;
    assign legal    = (op_sel <= OP_LAST);

    simd_bytelogic #(.VEC_W(VEC_W)) u_logic (
        .op  (op_sel),
        .imm (imm),
        .src (src_vec),
        .dst (dst_vec),
        .out (logic_out)
    );

    for (genvar w = 0; w < NUM_SHF; w++) begin : g_shf
        simd_lane_shuffle #(.VEC_W(VEC_W), .LANE_W(BYTE_W << w)) u_shf (
            .imm (imm),
            .src (src_vec),
            .out (shf_out[w])
        );
    end

    // Choose the datapath output that the operation code names.
    always_comb begin
        case (op_sel)
            OP_SHF_B: next_res = shf_out[0];
            OP_SHF_H: next_res = shf_out[1];
            OP_SHF_W: next_res = shf_out[2];
            default:  next_res = logic_out;
        endcase
    end

    // Result register and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vec <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= accept && legal;
            illegal <= accept && !legal;
            if (accept && legal) begin
                res_vec <= next_res;
            end
        end
    end

    p_done_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel <= 4'd9) |=> (done && !illegal));

    p_illegal_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel > 4'd9) |=> (illegal && !done && $stable(res_vec)));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!done && !illegal && $stable(res_vec)));

    p_merge_full_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd4 && imm == 8'hFF) |=> (res_vec == $past(src_vec)));

    p_shf_identity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd7 && imm == 8'hE4) |=> (res_vec == $past(src_vec)));

endmodule

// File: tb/simd_imm_unit_tb.sv
`timescale 1ns/1ps
module simd_imm_unit_tb;

    typedef struct packed {
        logic         ill;
        logic [3:0]   op;
        logic [127:0] res;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [3:0]   op_sel = '0;
    logic [7:0]   imm = '0;
    logic [127:0] src_vec = '0;
    logic [127:0] dst_vec = '0;
    logic [127:0] res_vec;
    logic         done;
    logic         illegal;

    int checks = 0;
    int failures = 0;
    bit running = 1'b0;
    exp_t q[$];
    logic [127:0] mon_last = '0;

    always #10 clk = ~clk;

    simd_imm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_sel(op_sel), .imm(imm), .src_vec(src_vec), .dst_vec(dst_vec),
        .res_vec(res_vec), .done(done), .illegal(illegal)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd3: return "R2";
            4'd2: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R11";
        endcase
    endfunction

    // Reference model written from the requirements.
    function automatic logic [127:0] model(input logic [3:0] op, input logic [7:0] m,
                                           input logic [127:0] s, input logic [127:0] d);
        logic [127:0] r;
        r = '0;
        if (op <= 4'd6) begin
            for (int b = 0; b < 16; b++) begin
                for (int t = 0; t < 8; t++) begin
                    logic sb, db, mb, o;
                    sb = s[b*8+t]; db = d[b*8+t]; mb = m[t];
                    case (op)
                        4'd0: o = sb & mb;
                        4'd1: o = sb | mb;
                        4'd2: o = !(sb | mb);
                        4'd3: o = sb ^ mb;
                        4'd4: o = mb ? sb : db;
                        4'd5: o = mb ? db : sb;
                        default: o = db ? mb : sb;
                    endcase
                    r[b*8+t] = o;
                end
            end
        end else if (op == 4'd7) begin
            for (int i = 0; i < 16; i++) begin
                int k;
                k = (m >> (2*(i%4))) & 3;
                r[i*8 +: 8] = s[(i - i%4 + k)*8 +: 8];
            end
        end else if (op == 4'd8) begin
            for (int i = 0; i < 8; i++) begin
                int k;
                k = (m >> (2*(i%4))) & 3;
                r[i*16 +: 16] = s[(i - i%4 + k)*16 +: 16];
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                int j;
                j = (m >> (2*i)) & 3;
                r[i*32 +: 32] = s[j*32 +: 32];
            end
        end
        return r;
    endfunction

    logic [127:0] drv_model = '0;

    // Driver: present one instruction after a rising edge and queue its expectation.
    task automatic issue(input logic [3:0] op, input logic [7:0] m,
                         input logic [127:0] s, input logic [127:0] d);
        exp_t e;
        @(posedge clk); #2;
        in_valid = 1'b1; op_sel = op; imm = m; src_vec = s; dst_vec = d;
        if (op > 4'd9) begin
            e.ill = 1'b1;
        end else begin
            e.ill = 1'b0;
            drv_model = model(op, m, s, d);
        end
        e.op = op;
        e.res = drv_model;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(posedge clk); #2;
            in_valid = 1'b0; op_sel = $urandom_range(0, 15); imm = 8'h3C;
            src_vec = {4{32'hDEADBEEF}}; dst_vec = ~src_vec;
        end
    endtask

    // Monitor: compare pulses with the oldest expectation; otherwise result must hold.
    always @(negedge clk) begin
        if (running) begin
            if (done || illegal) begin
                exp_t e;
                checks++;
                if (q.size() == 0) begin
                    failures++;
                    $display("FAIL R12: unexpected pulse done=%0b illegal=%0b expected none", done, illegal);
                end else begin
                    e = q.pop_front();
                    if (illegal !== e.ill || done !== !e.ill) begin
                        failures++;
                        $display("FAIL %s R10: done=%0b illegal=%0b expected done=%0b illegal=%0b op=%0d",
                                 req_of(e.op), done, illegal, !e.ill, e.ill, e.op);
                    end
                    checks++;
                    if (res_vec !== e.res) begin
                        failures++;
                        $display("FAIL %s: op=%0d res=%h expected %h", req_of(e.op), e.op, res_vec, e.res);
                    end
                    mon_last = e.res;
                end
            end else begin
                checks++;
                if (res_vec !== mon_last) begin
                    failures++;
                    $display("FAIL R12: idle res=%h expected %h", res_vec, mon_last);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] pa, pb, da, db;
        logic [7:0] imms [6];
        imms[0] = 8'h00; imms[1] = 8'hFF; imms[2] = 8'h5A;
        imms[3] = 8'hE4; imms[4] = 8'h1B; imms[5] = 8'hA5;
        for (int i = 0; i < 16; i++) begin
            pa[i*8 +: 8] = 8'h10 + 8'(i);
            pb[i*8 +: 8] = 8'(i * 37 + 5);
            da[i*8 +: 8] = 8'hF0 ^ 8'(i * 11);
            db[i*8 +: 8] = 8'(8'h81 + i * 3);
        end

        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        checks++;
        if (res_vec !== '0 || done !== 1'b0 || illegal !== 1'b0) begin
            failures++;
            $display("FAIL R1: res=%h done=%0b illegal=%0b expected 0/0/0", res_vec, done, illegal);
        end
        // R10: always ready
        checks++;
        if (in_ready !== 1'b1) begin
            failures++;
            $display("FAIL R10: in_ready=%0b expected 1", in_ready);
        end
        @(posedge clk); #2;
        rst_n = 1'b1;
        running = 1'b1;

        // Isolated instructions: every defined code against several immediates.
        for (int op = 0; op < 10; op++) begin
            for (int k = 0; k < 6; k++) begin
                issue(4'(op), imms[k], pa, da);
                idle(1);
            end
        end
        // R11: undefined codes leave the result alone.
        for (int op = 10; op < 16; op++) begin
            issue(4'(op), 8'h77, pb, db);
            idle(1);
        end
        // Back-to-back stream, mixing defined and undefined codes.
        for (int op = 0; op < 16; op++) begin
            issue(4'(op), imms[op % 6] ^ 8'(op), pb, db);
        end
        idle(3);
        for (int k = 0; k < 6; k++) begin
            issue(4'd8, imms[k], pb, da);
            issue(4'd9, imms[k], pa, db);
            issue(4'd6, imms[k], pb, db);
        end
        idle(4);

        running = 1'b0;
        // R10: every queued result must have arrived.
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R10: %0d results missing expected 0", q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule